// File: doc/BRIEF.md
# Arrow Warning Sign Lamp Sequencer

This block paces the five lamps of an arrow-shaped warning sign through a repeating build-up pattern. The lamps are wired in three groups: the pair at the tail, the middle pair, and the single lamp at the tip. While the enable switch is on, each clock edge moves the display one phase forward. The phases are dark, then tail pair, then tail and middle pairs, then all five lamps, and then dark again. As the phases advance, the groups light one on top of the other.

The sequencer is a Moore machine. A two-bit phase register holds the current phase. The next phase is chosen from the register and the switch. The lamp outputs are decoded from the register alone. If the switch is sampled low, the register returns to the dark phase at that edge, whatever phase it was in. Any clock divider that sets the blink rate sits outside this block, as do the lamp drivers.

Top module: `arrow_sign_seq`

## Requirements
- R1: A synchronous active-high reset puts the machine in the dark phase (phase code 00). All three lamp outputs are 0 while reset is sampled high, even with the switch on.
- R2: While the switch is sampled 1, the phase code advances by one at each rising edge in the order 00, 01, 10, 11 and then wraps to 00.
- R3: When the switch is sampled 0 at a rising edge, the phase code after that edge is 00, whichever phase was current.
- R4: The tail-pair output is 1 in phases 01, 10 and 11, and 0 in phase 00.
- R5: The middle-pair output is 1 only in phases 10 and 11.
- R6: The tip output is 1 only in phase 11.
- R7: The lamp outputs depend only on the phase register. Changing the switch between clock edges leaves them unchanged until the next edge.
- R8: Starting from the dark phase, the tail pair lights right after the first rising edge at which the switch is sampled 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; phases change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| switchOn | input | 1 | Enable switch; 1 runs the sequence, 0 returns to dark |
| lampPair | output | 1 | Drives the tail lamp pair (lamps 1 and 2) |
| lampQuad | output | 1 | Drives the middle lamp pair (lamps 3 and 4) |
| lampTip | output | 1 | Drives the tip lamp (lamp 5) |

## Verification
The switch value and the reset take effect one rising edge after they are sampled: the register updates at that edge, and the lamps follow it through combinational decode with no extra delay. The bench drives inputs and reads outputs 1 ns after each rising edge. At that point the outputs already show the phase chosen at that edge, and the next input has not yet been sampled. To show the Moore property, the switch is also toggled twice within one cycle, and the outputs are checked after each toggle. Each of those checks expects the phase from before the toggles.

// File: rtl/arrow_sign_pkg.sv
package arrow_sign_pkg;

  // Number of cumulatively lit lamp groups; the sequence has one more phase (dark).
  localparam int NUM_GROUPS = 3;
  localparam int NUM_PHASES = NUM_GROUPS + 1;
  localparam int PHASE_W    = $clog2(NUM_PHASES);

  typedef logic [PHASE_W-1:0] phase_t;

  localparam phase_t PHASE_DARK = '0;
  localparam phase_t PHASE_LAST = phase_t'(NUM_PHASES - 1);

  // Strobes passed from control to datapath: one-hot copy of the current phase.
  typedef struct packed {
    logic [NUM_PHASES-1:0] phaseHot;
  } lamp_ctrl_t;

endpackage

// File: rtl/arrow_sign_ctrl.sv
module arrow_sign_ctrl
  import arrow_sign_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       switchOn,
  output lamp_ctrl_t ctrl
);

  phase_t phaseQ;
  phase_t phaseNext;

  always_comb begin
    if (!switchOn) begin
      phaseNext = PHASE_DARK;
    end else if (phaseQ == PHASE_LAST) begin
      phaseNext = PHASE_DARK;
    end else begin
      phaseNext = phaseQ + phase_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= PHASE_DARK;
    end else begin
      phaseQ <= phaseNext;
    end
  end

  always_comb begin
    ctrl.phaseHot = '0;
    ctrl.phaseHot[phaseQ] = 1'b1;
  end

  // R2: with the switch on, the phase steps forward by one and wraps
  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    switchOn |=> (phaseQ == (($past(phaseQ) == PHASE_LAST) ? PHASE_DARK
                                                            : phase_t'($past(phaseQ) + phase_t'(1)))));

  // R3: switch off returns to dark at the next edge
  p_off_dark_r3: assert property (@(posedge clk) disable iff (rst)
    !switchOn |=> (phaseQ == PHASE_DARK));

  // R1: the cycle after reset is sampled the machine is dark
  p_reset_dark_r1: assert property (@(posedge clk) disable iff (1'b0)
    rst |=> (phaseQ == PHASE_DARK));

  // Strobes to the datapath are exactly one-hot
  p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(ctrl.phaseHot) == 1);

endmodule

// File: rtl/arrow_sign_lamps.sv
module arrow_sign_lamps
  import arrow_sign_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  lamp_ctrl_t            ctrl,
  output logic [NUM_GROUPS-1:0] lampOn
);

  // Group g is lit in every phase numbered above g: cumulative build-up.
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    assign lampOn[g] = |ctrl.phaseHot[NUM_PHASES-1:g+1];
  end

  // R5 and R6: a higher group never lights without the one below it
  for (genvar g = 1; g < NUM_GROUPS; g++) begin : g_chk
    p_stack_r5: assert property (@(posedge clk) disable iff (rst)
      lampOn[g] |-> lampOn[g-1]);
  end

  // R4: dark phase strobe means all lamps off
  p_dark_off_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl.phaseHot[0] |-> (lampOn == '0));

  // R6: only the final phase lights the tip group
  p_tip_last_r6: assert property (@(posedge clk) disable iff (rst)
    lampOn[NUM_GROUPS-1] |-> ctrl.phaseHot[NUM_PHASES-1]);

  // R7: outputs move only when the control strobes move
  p_moore_r7: assert property (@(posedge clk) disable iff (rst)
    $stable(ctrl) |-> $stable(lampOn));

endmodule

// File: rtl/arrow_sign_seq.sv
module arrow_sign_seq
  import arrow_sign_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic switchOn,
  output logic lampPair,
  output logic lampQuad,
  output logic lampTip
);

  lamp_ctrl_t            ctrl;
  logic [NUM_GROUPS-1:0] lampOn;

  arrow_sign_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .switchOn (switchOn),
    .ctrl     (ctrl)
  );

  arrow_sign_lamps u_lamps (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .lampOn (lampOn)
  );

  assign lampPair = lampOn[0];
  assign lampQuad = lampOn[1];
  assign lampTip  = lampOn[2];

endmodule

// File: tb/arrow_sign_seq_test.sv
`timescale 1ns/1ps
module arrow_sign_seq_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic switchOn = 1'b0;
  logic lampPair, lampQuad, lampTip;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  arrow_sign_seq uut (
    .clk      (clk),
    .rst      (rst),
    .switchOn (switchOn),
    .lampPair (lampPair),
    .lampQuad (lampQuad),
    .lampTip  (lampTip)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Expected lamps for phase p: {tip, quad, pair} = {p>=3, p>=2, p>=1}
  task automatic chk(input int p, input string req);
    logic [2:0] exp;
    logic [2:0] act;
    exp = {p >= 3, p >= 2, p >= 1};
    act = {lampTip, lampQuad, lampPair};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s phase %0d: lamps tip/quad/pair actual %b expected %b", req, p, act, exp);
    end
  endtask

  task automatic go_dark();
    switchOn = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    rst = 1'b1; switchOn = 1'b1;
    tick(); chk(0, "R1");
    tick(); chk(0, "R1");
    rst = 1'b0; switchOn = 1'b0;
    tick(); chk(0, "R1");
  endtask

  task automatic t_first_lit();
    go_dark(); chk(0, "R8");
    switchOn = 1'b1;
    #0.5 chk(0, "R8");
    tick(); chk(1, "R8");
  endtask

  task automatic t_sequence();
    // continues from phase 1 with switch on
    tick(); chk(2, "R2 R5");
    tick(); chk(3, "R2 R6");
    tick(); chk(0, "R2 R4");
    tick(); chk(1, "R2 R4");
    tick(); chk(2, "R2 R5");
    tick(); chk(3, "R2 R6");
    tick(); chk(0, "R2");
  endtask

  task automatic t_off_each();
    for (int s = 1; s <= 3; s++) begin
      go_dark();
      switchOn = 1'b1;
      for (int k = 0; k < s; k++) tick();
      chk(s, "R2");
      switchOn = 1'b0;
      tick(); chk(0, "R3");
      tick(); chk(0, "R3");
    end
  endtask

  task automatic t_moore();
    go_dark();
    switchOn = 1'b1;
    tick(); tick(); chk(2, "R7");
    switchOn = 1'b0;
    #1 chk(2, "R7");
    switchOn = 1'b1;
    #1 chk(2, "R7");
    tick(); chk(3, "R7");
  endtask

  task automatic t_reset_mid();
    // in phase 3 with switch on from t_moore
    rst = 1'b1;
    tick(); chk(0, "R1");
    tick(); chk(0, "R1");
    rst = 1'b0;
    tick(); chk(1, "R1 R8");
    switchOn = 1'b0;
    tick(); chk(0, "R3");
  endtask

  initial begin
    t_reset();
    t_first_lit();
    t_sequence();
    t_off_each();
    t_moore();
    t_reset_mid();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    nFails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule